// File: doc/BRIEF.md
# Programmable Almost-Full / Almost-Empty Flag Generator

This block turns the current fill level of a FIFO into three registered, active-low status flags: almost-full, almost-empty and half-full. The word count is produced elsewhere and sampled every clock. The flags show the count from the previous clock edge. The almost-full threshold is set by a full-side offset counted down from the depth. The almost-empty threshold is set by an empty-side offset counted up from zero. The half-full flag marks the midpoint of the memory.

Both offsets are held inside the block. While reset is active, a select input picks one of two default offsets, and both offsets take that value. After reset, a write strobe captures new offsets. The flags use an offset from the same edge that captures it, so a change of offset shows on the flags one clock later, with no extra delay.

Top module: `fifo_level_flags`

## Requirements
- R1: While `rstN` is low at a rising edge, the next flag values are `almostEmptyN`=0, `almostFullN`=1 and `halfFullN`=1, whatever the count.
- R2: Outside reset, `almostFullN` is 0 exactly when the count sampled at the previous edge is strictly greater than DEPTH minus the full offset.
- R3: Outside reset, `almostEmptyN` is 0 exactly when the count sampled at the previous edge is strictly less than the empty offset.
- R4: Outside reset, `halfFullN` is 0 exactly when the count sampled at the previous edge is strictly greater than DEPTH/2.
- R5: While reset is active, `dfltSel`=0 loads both offsets with DFLT_SMALL and `dfltSel`=1 loads both with DFLT_LARGE.
- R6: A rising edge with `ofsWrite`=1 outside reset captures `fullOfsIn` and `emptyOfsIn`. The flags computed at that same edge already use the new offsets.
- R7: While `ofsWrite` is 0, changes on `fullOfsIn` and `emptyOfsIn` have no effect on the flags.
- R8: The flags are registered. A count change made between edges does not reach the flags before the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| dfltSel | input | 1 | Selects the default offset while reset is active (0 small, 1 large) |
| ofsWrite | input | 1 | Strobe that captures both offset inputs |
| fullOfsIn | input | DEPTH_LOG2 | New full-side offset |
| emptyOfsIn | input | DEPTH_LOG2 | New empty-side offset |
| wordCount | input | DEPTH_LOG2+1 | Current number of stored words, 0..DEPTH |
| almostFullN | output | 1 | Active-low almost-full flag |
| almostEmptyN | output | 1 | Active-low almost-empty flag |
| halfFullN | output | 1 | Active-low half-full flag |

## Verification
An offset write and a change of the count can land on the same rising edge. When they do, the flags must be judged against the new count and the new offset together, not against the offset that was held before. The bench provokes this on every step of an offset sweep: it drives a fresh count and a fresh pair of offsets in the same cycle with the write strobe high. It then compares all three flags with values it works out from the new pair alone. In the same sweep, one offset rises while the other falls, so many steps cross both thresholds at once.

// File: rtl/fifo_flag_pkg.sv
package fifo_flag_pkg;

  typedef struct packed {
    logic clear;
    logic fullHit;
    logic emptyHit;
    logic halfHit;
  } flagStrobe_t;

endpackage

// File: rtl/fifo_flag_ctrl.sv
module fifo_flag_ctrl
  import fifo_flag_pkg::*;
#(
  parameter int DEPTH_LOG2 = 12,
  parameter int DFLT_SMALL = 127,
  parameter int DFLT_LARGE = 1023
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  dfltSel,
  input  logic                  ofsWrite,
  input  logic [DEPTH_LOG2-1:0] fullOfsIn,
  input  logic [DEPTH_LOG2-1:0] emptyOfsIn,
  input  logic [DEPTH_LOG2:0]   wordCount,
  output flagStrobe_t           strobe
);
  localparam int OFS_W = DEPTH_LOG2;
  localparam int CNT_W = DEPTH_LOG2 + 1;
  localparam int EXT_W = CNT_W + 1;
  localparam logic [EXT_W-1:0] DEPTH_EXT = EXT_W'(1) << DEPTH_LOG2;
  localparam logic [CNT_W-1:0] HALF_CNT  = CNT_W'(1) << (DEPTH_LOG2 - 1);
  localparam logic [OFS_W-1:0] SMALL_V   = OFS_W'(DFLT_SMALL);
  localparam logic [OFS_W-1:0] LARGE_V   = OFS_W'(DFLT_LARGE);

  logic [OFS_W-1:0] fullHeld, emptyHeld;
  logic [OFS_W-1:0] fullEff, emptyEff;
  logic [EXT_W-1:0] fullLimit;
  logic [EXT_W-1:0] countExt;

  // Held offsets: defaults during reset, captured on write strobe afterwards
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fullHeld  <= dfltSel ? LARGE_V : SMALL_V;
      emptyHeld <= dfltSel ? LARGE_V : SMALL_V;
    end else if (ofsWrite) begin
      fullHeld  <= fullOfsIn;
      emptyHeld <= emptyOfsIn;
    end
  end

  // A write in this cycle is used at once so the flags follow on the next edge
  always_comb begin
    fullEff   = ofsWrite ? fullOfsIn  : fullHeld;
    emptyEff  = ofsWrite ? emptyOfsIn : emptyHeld;
    countExt  = {1'b0, wordCount};
    fullLimit = DEPTH_EXT - {{(EXT_W-OFS_W){1'b0}}, fullEff};
  end

  always_comb begin
    strobe.clear    = !rstN;
    strobe.fullHit  = countExt > fullLimit;
    strobe.emptyHit = wordCount < {1'b0, emptyEff};
    strobe.halfHit  = wordCount > HALF_CNT;
  end

  // R5: both offsets take the selected default after a reset edge
  assert_default_ofs_R5: assert property (@(posedge clk)
    !rstN |=> (fullHeld == ($past(dfltSel) ? LARGE_V : SMALL_V)) &&
              (emptyHeld == ($past(dfltSel) ? LARGE_V : SMALL_V)));

  // R6: a write strobe outside reset captures both inputs
  assert_ofs_capture_R6: assert property (@(posedge clk) disable iff (!rstN)
    ofsWrite |=> (fullHeld == $past(fullOfsIn)) && (emptyHeld == $past(emptyOfsIn)));

  // R7: without a write strobe the held offsets do not move
  assert_ofs_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !ofsWrite |=> $stable(fullHeld) && $stable(emptyHeld));
endmodule

// File: rtl/fifo_flag_dp.sv
module fifo_flag_dp
  import fifo_flag_pkg::*;
(
  input  logic        clk,
  input  flagStrobe_t strobe,
  output logic        almostFullN,
  output logic        almostEmptyN,
  output logic        halfFullN
);
  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      almostFullN  <= 1'b1;
      almostEmptyN <= 1'b0;
      halfFullN    <= 1'b1;
    end else begin
      almostFullN  <= ~strobe.fullHit;
      almostEmptyN <= ~strobe.emptyHit;
      halfFullN    <= ~strobe.halfHit;
    end
  end

  // R1: a clear strobe yields the idle flag pattern one edge later
  assert_reset_flags_R1: assert property (@(posedge clk)
    strobe.clear |=> almostFullN && !almostEmptyN && halfFullN);
endmodule

// File: rtl/fifo_level_flags.sv
module fifo_level_flags
  import fifo_flag_pkg::*;
#(
  parameter int DEPTH_LOG2 = 12,
  parameter int DFLT_SMALL = 127,
  parameter int DFLT_LARGE = 1023
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  dfltSel,
  input  logic                  ofsWrite,
  input  logic [DEPTH_LOG2-1:0] fullOfsIn,
  input  logic [DEPTH_LOG2-1:0] emptyOfsIn,
  input  logic [DEPTH_LOG2:0]   wordCount,
  output logic                  almostFullN,
  output logic                  almostEmptyN,
  output logic                  halfFullN
);
  localparam int CNT_W = DEPTH_LOG2 + 1;
  localparam int DEPTH = 1 << DEPTH_LOG2;
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);

  flagStrobe_t strobe;

  fifo_flag_ctrl #(
    .DEPTH_LOG2(DEPTH_LOG2),
    .DFLT_SMALL(DFLT_SMALL),
    .DFLT_LARGE(DFLT_LARGE)
  ) ctrlI (
    .clk       (clk),
    .rstN      (rstN),
    .dfltSel   (dfltSel),
    .ofsWrite  (ofsWrite),
    .fullOfsIn (fullOfsIn),
    .emptyOfsIn(emptyOfsIn),
    .wordCount (wordCount),
    .strobe    (strobe)
  );

  fifo_flag_dp dpI (
    .clk         (clk),
    .strobe      (strobe),
    .almostFullN (almostFullN),
    .almostEmptyN(almostEmptyN),
    .halfFullN   (halfFullN)
  );

  // One edge after reset release the flags carry a computed value
  logic primed;
  always_ff @(posedge clk) begin
    if (!rstN) primed <= 1'b0;
    else       primed <= 1'b1;
  end

  // R4: half-full follows the previous count against the midpoint
  assert_half_full_R4: assert property (@(posedge clk) disable iff (!rstN)
    primed |-> (halfFullN == !($past(wordCount) > HALF_CNT)));

  // R2: almost-full never asserts at or below the half point when offset is small
  assert_full_vs_half_R2: assert property (@(posedge clk) disable iff (!rstN)
    (primed && !almostFullN && ($past(ctrlI.fullEff) <= DEPTH_LOG2'(DEPTH / 2)))
      |-> !halfFullN || ($past(wordCount) > CNT_W'(DEPTH - 32'($past(ctrlI.fullEff)))));

  // R3: almost-empty implies the previous count was below the used offset
  assert_empty_cmp_R3: assert property (@(posedge clk) disable iff (!rstN)
    (primed && !almostEmptyN) |-> ($past(wordCount) < {1'b0, $past(ctrlI.emptyEff)}));

  // Count input stays within the memory size
  assert_count_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    wordCount <= CNT_W'(DEPTH));
endmodule

// File: tb/fifo_level_flags_tb.sv
module fifo_level_flags_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LOG2  = 5;
  localparam int DEPTH = 1 << LOG2;
  localparam int SMALL = 3;
  localparam int LARGE = 7;

  logic clk = 1'b0;
  logic rstN, dfltSel, ofsWrite;
  logic [LOG2-1:0] fullOfsIn, emptyOfsIn;
  logic [LOG2:0] wordCount;
  logic almostFullN, almostEmptyN, halfFullN;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fifo_level_flags #(
    .DEPTH_LOG2(LOG2), .DFLT_SMALL(SMALL), .DFLT_LARGE(LARGE)
  ) dut_i (
    .clk(clk), .rstN(rstN), .dfltSel(dfltSel), .ofsWrite(ofsWrite),
    .fullOfsIn(fullOfsIn), .emptyOfsIn(emptyOfsIn), .wordCount(wordCount),
    .almostFullN(almostFullN), .almostEmptyN(almostEmptyN), .halfFullN(halfFullN)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  // Apply count (and optional offset write), then check after the edge
  task automatic step(input int c, input bit wr, input int m, input int n,
                      input int expM, input int expN, input string tag);
    @(negedge clk);
    wordCount  = (LOG2+1)'(c);
    ofsWrite   = wr;
    fullOfsIn  = LOG2'(m);
    emptyOfsIn = LOG2'(n);
    @(posedge clk);
    #1;
    chk({tag, " R2 almostFull"},  almostFullN,  !(c > DEPTH - expM));
    chk({tag, " R3 almostEmpty"}, almostEmptyN, !(c < expN));
    chk({tag, " R4 halfFull"},    halfFullN,    !(c > DEPTH / 2));
  endtask

  task automatic doReset(input bit sel);
    @(negedge clk);
    rstN = 1'b0; dfltSel = sel; wordCount = (LOG2+1)'(20); ofsWrite = 1'b1;
    fullOfsIn = '1; emptyOfsIn = '1;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 reset almostFull",  almostFullN,  1'b1);
    chk("R1 reset almostEmpty", almostEmptyN, 1'b0);
    chk("R1 reset halfFull",    halfFullN,    1'b1);
    @(negedge clk);
    rstN = 1'b1; ofsWrite = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; dfltSel = 1'b0; ofsWrite = 1'b0;
    fullOfsIn = '0; emptyOfsIn = '0; wordCount = '0;

    // R1 + R5 small default sweep
    doReset(1'b0);
    for (int c = 0; c <= DEPTH; c++) step(c, 0, 0, 0, SMALL, SMALL, "R5 small");

    // R7: garbage on offset inputs without strobe
    for (int c = DEPTH; c >= 0; c--) step(c, 0, 17, 29, SMALL, SMALL, "R7 ignore");

    // R5 large default
    doReset(1'b1);
    for (int c = 0; c <= DEPTH; c++) step(c, 0, 1, 1, LARGE, LARGE, "R5 large");

    // R6: write and count change in the same cycle, then sweep
    for (int k = 0; k < DEPTH; k++) begin
      step((k * 7) % (DEPTH + 1), 1, k, DEPTH - 1 - k, k, DEPTH - 1 - k, "R6 coincide");
      for (int c = 0; c <= DEPTH; c++)
        step(c, 0, (k + 5) % DEPTH, k, k, DEPTH - 1 - k, "R6 held");
    end

    // R8: count change between edges not visible until the edge
    step(0, 0, 0, 0, DEPTH - 1, 0, "R8 base");
    @(negedge clk);
    wordCount = (LOG2+1)'(DEPTH);
    #1;
    chk("R8 before edge almostFull", almostFullN, 1'b1);
    chk("R8 before edge halfFull",   halfFullN,   1'b1);
    @(posedge clk);
    #1;
    chk("R8 after edge almostFull", almostFullN, 1'b0);
    chk("R8 after edge halfFull",   halfFullN,   1'b0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule